// File: doc/BRIEF.md
# Dual-Issue Reorder Buffer with In-Order Retirement

This block tracks in-flight instructions for a two-wide superscalar core. It sits between the rename stage and four fully pipelined execution units: integer, memory, FP add and FP multiply. Each cycle the rename stage may offer up to two instructions in program order. Each instruction carries a unit class and two source tags, each with a ready flag. The buffer returns a destination tag for every accepted instruction. Tags come from a counter that only moves forward, so a live tag is never handed out twice.

An instruction waits until both of its sources are ready. It is then sent to its unit class. Each unit receives at most one instruction per cycle, and the oldest ready entry is chosen first. Result broadcasts may arrive on several writeback lanes in the same cycle. A broadcast wakes every entry waiting on that tag and marks the producing entry complete. Completed entries retire from the head in program order, at most two per cycle.

Nothing is forwarded within a cycle. A newly accepted entry, a newly woken source and a newly completed entry each take effect one cycle later. `DEPTH` must be a power of two, and `2**TAG_W` must be at least `2*DEPTH`.

Top module: `rob_dual_issue`

## Requirements
- R1: After reset, both allocation slots report ready, the offered tags are 0 and 1, and no dispatch or commit is signalled.
- R2: Slot 0 is ready while fewer than DEPTH entries are held. Slot 1 is ready only while at least two entries are free. When only one entry is free, an offered pair has only its slot-0 instruction accepted.
- R3: Accepted instructions receive consecutive tags in program order, slot 0 before slot 1. The offered tag advances by exactly the number of instructions accepted.
- R4: Each unit class (encoding 0 integer, 1 memory, 2 FP add, 3 FP multiply) receives at most one instruction per cycle. Each entry is dispatched once only.
- R5: An instruction accepted in cycle N is dispatched no earlier than cycle N+1.
- R6: When several entries of the same unit class are ready, the oldest one is dispatched first.
- R7: A writeback of tag T in cycle N makes entries waiting on T eligible for dispatch in cycle N+1, not earlier. This also holds for an entry being accepted in cycle N.
- R8: Any number of writeback lanes may carry results in the same cycle, and all of them take effect.
- R9: Commits leave strictly in tag order. An entry written back in cycle N commits no earlier than cycle N+1.
- R10: Up to two entries commit per cycle. The second commit lane is active only together with the first, and it carries the next tag.
- R11: An entry with a source not yet ready is never dispatched.
- R12: While DEPTH entries are held, both slots report not ready, and offered instructions leave the tag counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_vld_i | input | 2 | Instruction offered on slot 0 / slot 1 (slot 1 only with slot 0) |
| alloc_fu_i | input | 2x2 | Unit class per slot |
| alloc_src1_tag_i | input | 2xTAG_W | First source tag per slot |
| alloc_src1_rdy_i | input | 2 | First source already available |
| alloc_src2_tag_i | input | 2xTAG_W | Second source tag per slot |
| alloc_src2_rdy_i | input | 2 | Second source already available |
| alloc_rdy_o | output | 2 | Slot can be accepted this cycle |
| alloc_tag_o | output | 2xTAG_W | Destination tag given to each slot |
| disp_vld_o | output | 4 | Dispatch to unit class 0..3 |
| disp_tag_o | output | 4xTAG_W | Tag dispatched to each unit class |
| wb_vld_i | input | NUM_WB | Writeback lane valid |
| wb_tag_i | input | NUM_WBxTAG_W | Tag completed on each lane |
| cmt_vld_o | output | 2 | Commit lane valid |
| cmt_tag_o | output | 2xTAG_W | Tag committed on each lane |

## Verification
A corrupted ready or done bit shows up at the ports as a dispatch or commit that is missing or early. Because nothing is forwarded, this appears exactly one cycle away from the expected cycle. The bench therefore checks every dispatch and commit at its exact cycle. A broken age order or a broken head/tail counter shows up in the next cycle as a wrong tag on a dispatch or commit lane. A miscounted occupancy is first visible when the buffer fills or drains, as a slot-ready pattern that does not match the number of held entries.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  localparam int NUM_FU = 4;
  typedef enum logic [1:0] {
    FU_ALU  = 2'd0,
    FU_MEM  = 2'd1,
    FU_FADD = 2'd2,
    FU_FMUL = 2'd3
  } fu_e;
endpackage

// File: rtl/rob_alloc_ctrl.sv
`timescale 1ns/1ps
module rob_alloc_ctrl #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 alloc_vld_i,
  input  logic [1:0]                 cmt_vld_i,
  output logic [1:0]                 alloc_rdy_o,
  output logic [1:0]                 acc_o,
  output logic [1:0][TAG_W-1:0]      alloc_tag_o,
  output logic [$clog2(DEPTH)-1:0]   head_idx_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [TAG_W-1:0] DEPTH_T = TAG_W'(DEPTH);

  logic [TAG_W-1:0] head_q, tail_q, occ;

  // occupancy ignores same-cycle commits: no retire-to-alloc bypass
  assign occ            = tail_q - head_q;
  assign alloc_rdy_o[0] = occ < DEPTH_T;
  assign alloc_rdy_o[1] = (DEPTH_T - occ) >= TAG_W'(2);
  assign acc_o[0]       = alloc_vld_i[0] & alloc_rdy_o[0];
  assign acc_o[1]       = acc_o[0] & alloc_vld_i[1] & alloc_rdy_o[1];
  assign alloc_tag_o[0] = tail_q;
  assign alloc_tag_o[1] = tail_q + TAG_W'(1);
  assign head_idx_o     = head_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      tail_q <= tail_q + TAG_W'(acc_o[0]) + TAG_W'(acc_o[1]);
      head_q <= head_q + TAG_W'(cmt_vld_i[0]) + TAG_W'(cmt_vld_i[1]);
    end
  end
endmodule

// File: rtl/rob_age_picker.sv
`timescale 1ns/1ps
module rob_age_picker #(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]           req_i,
  input  logic [$clog2(DEPTH)-1:0]   head_idx_i,
  output logic                       gnt_vld_o,
  output logic [$clog2(DEPTH)-1:0]   gnt_idx_o
);
  localparam int IDX_W = $clog2(DEPTH);

  // scan from head so the first hit is the oldest
  always_comb begin
    logic             found;
    logic [IDX_W-1:0] idx;
    found     = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx_i + IDX_W'(k);
      if (!found && req_i[idx]) begin
        found     = 1'b1;
        gnt_idx_o = idx;
      end
    end
    gnt_vld_o = found;
  end
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
module rob_retire #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0][TAG_W-1:0]  dst_i,
  input  logic [$clog2(DEPTH)-1:0]     head_idx_i,
  output logic [1:0]                   cmt_vld_o,
  output logic [1:0][TAG_W-1:0]        cmt_tag_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] idx1;

  assign idx1         = head_idx_i + IDX_W'(1);
  assign cmt_vld_o[0] = vld_i[head_idx_i] & done_i[head_idx_i];
  assign cmt_vld_o[1] = cmt_vld_o[0] & vld_i[idx1] & done_i[idx1];
  assign cmt_tag_o[0] = dst_i[head_idx_i];
  assign cmt_tag_o[1] = dst_i[idx1];
endmodule

// File: rtl/rob_dual_issue.sv
`timescale 1ns/1ps
module rob_dual_issue
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int NUM_WB = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     alloc_vld_i,
  input  logic [1:0][1:0]                alloc_fu_i,
  input  logic [1:0][TAG_W-1:0]          alloc_src1_tag_i,
  input  logic [1:0]                     alloc_src1_rdy_i,
  input  logic [1:0][TAG_W-1:0]          alloc_src2_tag_i,
  input  logic [1:0]                     alloc_src2_rdy_i,
  output logic [1:0]                     alloc_rdy_o,
  output logic [1:0][TAG_W-1:0]          alloc_tag_o,
  output logic [NUM_FU-1:0]              disp_vld_o,
  output logic [NUM_FU-1:0][TAG_W-1:0]   disp_tag_o,
  input  logic [NUM_WB-1:0]              wb_vld_i,
  input  logic [NUM_WB-1:0][TAG_W-1:0]   wb_tag_i,
  output logic [1:0]                     cmt_vld_o,
  output logic [1:0][TAG_W-1:0]          cmt_tag_o
);
  localparam int IDX_W = $clog2(DEPTH);

  // entry storage
  logic [DEPTH-1:0]            ent_vld, ent_disp, ent_done;
  logic [DEPTH-1:0]            ent_s1_rdy, ent_s2_rdy;
  logic [DEPTH-1:0][1:0]       ent_fu;
  logic [DEPTH-1:0][TAG_W-1:0] ent_s1_tag, ent_s2_tag, ent_dst;

  logic [1:0]                  acc;
  logic [IDX_W-1:0]            head_idx;
  logic [1:0]                  slot_s1_wb, slot_s2_wb;
  logic [DEPTH-1:0]            s1_wake, s2_wake, done_hit, disp_set, cmt_clr;
  logic [DEPTH-1:0]            new_hit, new_sel;
  logic [NUM_FU-1:0][DEPTH-1:0] fu_req;
  logic [NUM_FU-1:0]           gnt_vld;
  logic [NUM_FU-1:0][IDX_W-1:0] gnt_idx;

  rob_alloc_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_vld_i (alloc_vld_i),
    .cmt_vld_i   (cmt_vld_o),
    .alloc_rdy_o (alloc_rdy_o),
    .acc_o       (acc),
    .alloc_tag_o (alloc_tag_o),
    .head_idx_o  (head_idx)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    rob_age_picker #(.DEPTH(DEPTH)) u_pick (
      .req_i      (fu_req[u]),
      .head_idx_i (head_idx),
      .gnt_vld_o  (gnt_vld[u]),
      .gnt_idx_o  (gnt_idx[u])
    );
    assign disp_vld_o[u] = gnt_vld[u];
    assign disp_tag_o[u] = ent_dst[gnt_idx[u]];
  end

  rob_retire #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_retire (
    .vld_i      (ent_vld),
    .done_i     (ent_done),
    .dst_i      (ent_dst),
    .head_idx_i (head_idx),
    .cmt_vld_o  (cmt_vld_o),
    .cmt_tag_o  (cmt_tag_o)
  );

  // wakeups for instructions being accepted this cycle
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      slot_s1_wb[k] = alloc_src1_rdy_i[k];
      slot_s2_wb[k] = alloc_src2_rdy_i[k];
      for (int w = 0; w < NUM_WB; w++) begin
        if (wb_vld_i[w] && wb_tag_i[w] == alloc_src1_tag_i[k]) slot_s1_wb[k] = 1'b1;
        if (wb_vld_i[w] && wb_tag_i[w] == alloc_src2_tag_i[k]) slot_s2_wb[k] = 1'b1;
      end
    end
  end

  // per-entry next-state terms
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      s1_wake[i]  = 1'b0;
      s2_wake[i]  = 1'b0;
      done_hit[i] = 1'b0;
      for (int w = 0; w < NUM_WB; w++) begin
        if (wb_vld_i[w] && wb_tag_i[w] == ent_s1_tag[i]) s1_wake[i] = 1'b1;
        if (wb_vld_i[w] && wb_tag_i[w] == ent_s2_tag[i]) s2_wake[i] = 1'b1;
        if (wb_vld_i[w] && wb_tag_i[w] == ent_dst[i])    done_hit[i] = ent_vld[i];
      end
      disp_set[i] = 1'b0;
      for (int u = 0; u < NUM_FU; u++) begin
        fu_req[u][i] = ent_vld[i] & ~ent_disp[i] & ent_s1_rdy[i] & ent_s2_rdy[i]
                       & (ent_fu[i] == 2'(u));
        if (gnt_vld[u] && gnt_idx[u] == IDX_W'(i)) disp_set[i] = 1'b1;
      end
      cmt_clr[i] = (cmt_vld_o[0] && head_idx == IDX_W'(i)) ||
                   (cmt_vld_o[1] && head_idx + IDX_W'(1) == IDX_W'(i));
      new_sel[i] = acc[1] && alloc_tag_o[1][IDX_W-1:0] == IDX_W'(i);
      new_hit[i] = new_sel[i] || (acc[0] && alloc_tag_o[0][IDX_W-1:0] == IDX_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld    <= '0;
      ent_disp   <= '0;
      ent_done   <= '0;
      ent_s1_rdy <= '0;
      ent_s2_rdy <= '0;
      ent_fu     <= '0;
      ent_s1_tag <= '0;
      ent_s2_tag <= '0;
      ent_dst    <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (new_hit[i]) begin
          ent_vld[i]    <= 1'b1;
          ent_disp[i]   <= 1'b0;
          ent_done[i]   <= 1'b0;
          ent_fu[i]     <= alloc_fu_i[new_sel[i]];
          ent_s1_tag[i] <= alloc_src1_tag_i[new_sel[i]];
          ent_s2_tag[i] <= alloc_src2_tag_i[new_sel[i]];
          ent_s1_rdy[i] <= slot_s1_wb[new_sel[i]];
          ent_s2_rdy[i] <= slot_s2_wb[new_sel[i]];
          ent_dst[i]    <= alloc_tag_o[new_sel[i]];
        end else if (cmt_clr[i]) begin
          ent_vld[i] <= 1'b0;
        end else begin
          if (s1_wake[i])  ent_s1_rdy[i] <= 1'b1;
          if (s2_wake[i])  ent_s2_rdy[i] <= 1'b1;
          if (disp_set[i]) ent_disp[i]   <= 1'b1;
          if (done_hit[i]) ent_done[i]   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rob_dual_issue_chk.sv
`timescale 1ns/1ps
module rob_dual_issue_chk #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int NUM_WB = 4,
  parameter int NUM_FU = 4
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [1:0]                    alloc_vld_i,
  input logic [1:0]                    alloc_rdy_o,
  input logic [1:0][TAG_W-1:0]         alloc_tag_o,
  input logic [NUM_FU-1:0]             disp_vld_o,
  input logic [NUM_FU-1:0][TAG_W-1:0]  disp_tag_o,
  input logic [NUM_WB-1:0]             wb_vld_i,
  input logic [NUM_WB-1:0][TAG_W-1:0]  wb_tag_i,
  input logic [1:0]                    cmt_vld_o,
  input logic [1:0][TAG_W-1:0]         cmt_tag_o
);
  localparam logic [TAG_W-1:0] DEPTH_T = TAG_W'(DEPTH);

  logic             acc0, acc1, started, cmt_wb_hit;
  logic [TAG_W-1:0] acc_n, cmt_n, occ_q, exp_cmt_q;

  assign acc0  = alloc_vld_i[0] & alloc_rdy_o[0];
  assign acc1  = acc0 & alloc_vld_i[1] & alloc_rdy_o[1];
  assign acc_n = TAG_W'(acc0) + TAG_W'(acc1);
  assign cmt_n = TAG_W'(cmt_vld_o[0]) + TAG_W'(cmt_vld_o[1]);

  always_comb begin
    cmt_wb_hit = 1'b0;
    for (int w = 0; w < NUM_WB; w++)
      if (wb_vld_i[w] && wb_tag_i[w] == cmt_tag_o[0]) cmt_wb_hit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      exp_cmt_q <= '0;
      started   <= 1'b0;
    end else begin
      occ_q     <= occ_q + acc_n - cmt_n;
      exp_cmt_q <= exp_cmt_q + cmt_n;
      started   <= 1'b1;
    end
  end

  p_rdy_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_rdy_o[1] |-> alloc_rdy_o[0]);
  p_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q < DEPTH_T) |-> alloc_rdy_o[0]);
  p_full_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == DEPTH_T) |-> (alloc_rdy_o == 2'b00));
  p_tag_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |=> alloc_tag_o[0] == $past(alloc_tag_o[0]) + $past(acc_n));
  p_cmt_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_vld_o[0] |-> cmt_tag_o[0] == exp_cmt_q);
  p_cmt_nobyp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_vld_o[0] |-> !cmt_wb_hit);
  p_cmt_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_vld_o[1] |-> (cmt_vld_o[0] && cmt_tag_o[1] == cmt_tag_o[0] + TAG_W'(1)));

  for (genvar u = 0; u < NUM_FU; u++) begin : g_disp
    p_disp_new_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_vld_o[u] |-> !((acc0 && disp_tag_o[u] == alloc_tag_o[0]) ||
                          (acc1 && disp_tag_o[u] == alloc_tag_o[1])));
    p_disp_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_vld_o[u] |-> (disp_tag_o[u] - exp_cmt_q) < occ_q);
  end
endmodule

bind rob_dual_issue rob_dual_issue_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .NUM_WB(NUM_WB), .NUM_FU(rob_pkg::NUM_FU)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alloc_vld_i (alloc_vld_i),
  .alloc_rdy_o (alloc_rdy_o),
  .alloc_tag_o (alloc_tag_o),
  .disp_vld_o  (disp_vld_o),
  .disp_tag_o  (disp_tag_o),
  .wb_vld_i    (wb_vld_i),
  .wb_tag_i    (wb_tag_i),
  .cmt_vld_o   (cmt_vld_o),
  .cmt_tag_o   (cmt_tag_o)
);

// File: tb/rob_dual_issue_tb.sv
`timescale 1ns/1ps
module rob_dual_issue_tb;
  import rob_pkg::*;
  localparam int DEPTH = 8, TAG_W = 8, NUM_WB = 4;
  localparam int NOTAG = 255;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]                   alloc_vld_i;
  logic [1:0][1:0]              alloc_fu_i;
  logic [1:0][TAG_W-1:0]        alloc_src1_tag_i, alloc_src2_tag_i;
  logic [1:0]                   alloc_src1_rdy_i, alloc_src2_rdy_i;
  logic [1:0]                   alloc_rdy_o;
  logic [1:0][TAG_W-1:0]        alloc_tag_o;
  logic [NUM_FU-1:0]            disp_vld_o;
  logic [NUM_FU-1:0][TAG_W-1:0] disp_tag_o;
  logic [NUM_WB-1:0]            wb_vld_i;
  logic [NUM_WB-1:0][TAG_W-1:0] wb_tag_i;
  logic [1:0]                   cmt_vld_o;
  logic [1:0][TAG_W-1:0]        cmt_tag_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rob_dual_issue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_dut (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    alloc_vld_i = '0; alloc_fu_i = '0;
    alloc_src1_tag_i = '0; alloc_src2_tag_i = '0;
    alloc_src1_rdy_i = '0; alloc_src2_rdy_i = '0;
    wb_vld_i = '0; wb_tag_i = '0;
  endtask

  task automatic put(input int k, input fu_e fu, input int t1, input bit r1,
                     input int t2, input bit r2);
    alloc_vld_i[k] = 1'b1; alloc_fu_i[k] = fu;
    alloc_src1_tag_i[k] = TAG_W'(t1); alloc_src1_rdy_i[k] = r1;
    alloc_src2_tag_i[k] = TAG_W'(t2); alloc_src2_rdy_i[k] = r2;
  endtask

  task automatic wb(input int lane, input int tag);
    wb_vld_i[lane] = 1'b1; wb_tag_i[lane] = TAG_W'(tag);
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_disp(input string req, input int u, input bit v, input int tag);
    chk_eq({req, " disp_vld"}, int'(disp_vld_o[u]), int'(v));
    if (v) chk_eq({req, " disp_tag"}, int'(disp_tag_o[u]), tag);
  endtask

  task automatic chk_cmt(input string req, input int n, input int t0);
    chk_eq({req, " cmt_vld"}, int'(cmt_vld_o), (n == 2) ? 3 : n);
    if (n > 0) chk_eq({req, " cmt_tag0"}, int'(cmt_tag_o[0]), t0);
    if (n > 1) chk_eq({req, " cmt_tag1"}, int'(cmt_tag_o[1]), t0 + 1);
  endtask

  task automatic test_reset();
    chk_eq("R1 rdy", int'(alloc_rdy_o), 3);
    chk_eq("R1 tag0", int'(alloc_tag_o[0]), 0);
    chk_eq("R1 tag1", int'(alloc_tag_o[1]), 1);
    chk_eq("R1 disp", int'(disp_vld_o), 0);
    chk_eq("R1 cmt", int'(cmt_vld_o), 0);
  endtask

  // two ALU ops, tags 0,1
  task automatic test_basic();
    idle(); put(0, FU_ALU, 0, 1, 0, 1); put(1, FU_ALU, 0, 1, 0, 1);
    chk_eq("R5 none before entry", int'(disp_vld_o), 0);
    tick();
    idle();
    chk_disp("R5 R4", 0, 1, 0);
    chk_eq("R4 other units idle", int'(disp_vld_o[3:1]), 0);
    chk_eq("R3 tag advance by two", int'(alloc_tag_o[0]), 2);
    tick();
    chk_disp("R4 second ALU next cycle", 0, 1, 1);
    tick();
    chk_disp("R4 dispatched once", 0, 0, 0);
    wb(0, 0); wb(1, 1);
    chk_cmt("R9 no commit before wb", 0, 0);
    tick();
    idle();
    chk_cmt("R8 R10 pair commit", 2, 0);
    tick();
    chk_cmt("R10 drained", 0, 0);
  endtask

  // MEM producer tag2 -> FMUL consumer tag3
  task automatic test_dep();
    idle(); put(0, FU_MEM, 0, 1, 0, 1); put(1, FU_FMUL, 2, 0, 0, 1);
    tick();
    idle();
    chk_disp("R5 MEM", 1, 1, 2);
    chk_disp("R11 FMUL waits", 3, 0, 0);
    tick();
    wb(0, 2);
    chk_disp("R7 no same-cycle wake", 3, 0, 0);
    chk_cmt("R9 no same-cycle commit", 0, 0);
    tick();
    idle();
    chk_disp("R7 wake next cycle", 3, 1, 3);
    chk_disp("R4 MEM idle", 1, 0, 0);
    chk_cmt("R9 commit after wb", 1, 2);
    tick();
    wb(0, 3);
    chk_cmt("R9 consumer not done", 0, 0);
    tick();
    idle();
    chk_cmt("R9 consumer commit", 1, 3);
  endtask

  // wakeup captured while the consumer is being accepted: tags 4,5
  task automatic test_alloc_wb();
    idle(); put(0, FU_FADD, 0, 1, 0, 1);
    tick();
    idle();
    chk_disp("R5 FADD", 2, 1, 4);
    tick();
    wb(0, 4); put(0, FU_FADD, 4, 0, 0, 1);
    tick();
    idle();
    chk_disp("R7 wake during accept", 2, 1, 5);
    chk_cmt("R9 FADD commit", 1, 4);
    tick();
    wb(0, 5);
    tick();
    idle();
    chk_cmt("R9 second FADD", 1, 5);
  endtask

  // older ALU woken late vs younger ALU ready: tags 6,7,8
  task automatic test_oldest();
    idle(); put(0, FU_MEM, 0, 1, 0, 1); put(1, FU_ALU, 6, 0, 0, 1);
    tick();
    idle();
    chk_disp("R5 MEM", 1, 1, 6);
    put(0, FU_ALU, 0, 1, 0, 1); wb(0, 6);
    tick();
    idle();
    chk_disp("R6 oldest ALU first", 0, 1, 7);
    chk_cmt("R9 MEM commit", 1, 6);
    tick();
    chk_disp("R6 younger ALU next", 0, 1, 8);
    wb(0, 7); wb(1, 8);
    tick();
    idle();
    chk_cmt("R8 R10 pair", 2, 7);
  endtask

  // fill to DEPTH with waiting ALU ops: tags 9..16
  task automatic test_full();
    idle();
    chk_eq("R2 empty rdy", int'(alloc_rdy_o), 3);
    for (int c = 0; c < 3; c++) begin
      idle(); put(0, FU_ALU, NOTAG, 0, 0, 1); put(1, FU_ALU, NOTAG, 0, 0, 1);
      tick();
    end
    idle();
    chk_eq("R2 two free", int'(alloc_rdy_o), 3);
    put(0, FU_ALU, NOTAG, 0, 0, 1);
    tick();
    idle();
    chk_eq("R2 one free", int'(alloc_rdy_o), 1);
    put(0, FU_ALU, NOTAG, 0, 0, 1); put(1, FU_ALU, NOTAG, 0, 0, 1);
    tick();
    chk_eq("R12 full rdy", int'(alloc_rdy_o), 0);
    chk_eq("R2 R3 partial accept", int'(alloc_tag_o[0]), 17);
    tick();
    idle();
    chk_eq("R12 offers ignored", int'(alloc_tag_o[0]), 17);
    chk_eq("R11 no dispatch", int'(disp_vld_o), 0);
    wb(0, NOTAG);
    tick();
    idle();
    for (int j = 0; j < 8; j++) begin
      chk_disp("R6 R4 drain order", 0, 1, 9 + j);
      tick();
    end
    chk_disp("R4 all dispatched", 0, 0, 0);
    for (int w = 0; w < 4; w++) wb(w, 9 + w);
    tick();
    idle();
    for (int w = 0; w < 4; w++) wb(w, 13 + w);
    chk_cmt("R10 retire 9", 2, 9);
    tick();
    idle();
    for (int j = 0; j < 3; j++) begin
      chk_cmt("R10 retire pair", 2, 11 + 2 * j);
      tick();
    end
    chk_cmt("R10 empty", 0, 0);
    chk_eq("R2 free again", int'(alloc_rdy_o), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    test_reset();
    test_basic();
    tick(); test_dep();
    tick(); test_alloc_wb();
    tick(); test_oldest();
    tick(); test_full();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule